// File: doc/BRIEF.md
# Channel Byte FIFO with Programmable Threshold Flags

This block buffers bytes for one serial channel in a single clock domain. A producer pushes bytes through a valid/ready write port and a consumer takes them through a valid/ready read port in the order they were written. The block keeps a 16-bit occupancy count and reports the fixed capacity as a 16-bit constant. It also drives four condition flags, all active low: full, almost full, almost empty and empty. The two almost thresholds are programmable and reset to 7.

Back-pressure works as follows. `wr_ready` is high exactly when the buffer is not full, and `rd_valid` is high exactly when it is not empty. A byte moves when valid and ready are both high at a rising edge. A producer that keeps `wr_valid` high while `wr_ready` is low loses that byte, and a sticky overflow flag records the loss until it is cleared by a write-one input. A consumer that raises `rd_ready` while `rd_valid` is low gets the most recently read byte again and a one-cycle underflow pulse. A rising edge on `flush_req` empties the buffer once. When stop-on-full is enabled, a halt output tells an upstream receiver to stop once the buffer has filled.

Top module: `chan_byte_fifo`

## Requirements
- R1: Bytes leave in the order they were accepted. `wr_ready` = not full and `rd_valid` = not empty. While not empty, `rd_data` shows the oldest stored byte.
- R2: `fill_level` gives the number of stored bytes, updated at the edge that accepts a push or pop, and never exceeds the capacity. `depth_words` always reads the capacity (16 by default).
- R3: `full_n` is 0 exactly when the level equals the capacity. `empty_n` is 0 exactly when the level is 0. For all flags, 0 means the condition holds.
- R4: `afull_n` is 0 exactly when level >= capacity − `afull_thr`. A threshold above the capacity makes it always 0.
- R5: `aempty_n` is 0 exactly when level <= `aempty_thr`.
- R6: Both thresholds reset to 7. When `thr_we` is high at an edge, both are loaded from their inputs, and the new values are visible on `afull_thr`/`aempty_thr` after that edge.
- R7: A write offered while full is discarded: the level and contents are unchanged, and `ovf_flag` is set at the next edge. `ovf_flag` stays set until an edge with `ovf_clr` high. If a discard and a clear fall in the same cycle, the flag stays set.
- R8: A read offered while empty leaves the level unchanged. `rd_data` shows the last byte read out, or 0 if no byte has been read since reset. `udf_pulse` is high for exactly the one cycle after the attempt.
- R9: A push and a pop accepted in the same cycle leave `fill_level` unchanged.
- R10: A rising edge on `flush_req` empties the buffer at that clock edge, and a write offered in the same cycle is dropped without setting overflow. Holding `flush_req` high does not flush again.
- R11: With `stop_on_full` high, `rx_halt` rises at the edge after the buffer is full. It stays high until a flush or until `stop_on_full` is lowered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Producer offers `wr_data` |
| wr_ready | output | 1 | Buffer can accept a byte |
| wr_data | input | 8 | Byte to store |
| rd_valid | output | 1 | A byte is available |
| rd_ready | input | 1 | Consumer takes a byte |
| rd_data | output | 8 | Oldest byte, or last byte read when empty |
| flush_req | input | 1 | Empty the buffer on its rising edge |
| thr_we | input | 1 | Load both thresholds |
| afull_thr_in | input | 16 | New almost-full offset |
| aempty_thr_in | input | 16 | New almost-empty limit |
| afull_thr | output | 16 | Current almost-full offset |
| aempty_thr | output | 16 | Current almost-empty limit |
| fill_level | output | 16 | Stored byte count |
| depth_words | output | 16 | Capacity constant |
| full_n | output | 1 | Low when full |
| afull_n | output | 1 | Low when almost full |
| aempty_n | output | 1 | Low when almost empty |
| empty_n | output | 1 | Low when empty |
| ovf_clr | input | 1 | Write-one clear of overflow |
| ovf_flag | output | 1 | Sticky discarded-write flag |
| udf_pulse | output | 1 | One-cycle read-while-empty indication |
| stop_on_full | input | 1 | Enable halt on full |
| rx_halt | output | 1 | Tells the upstream receiver to stop |

## Verification
Each registered result appears at the first rising edge after its cause. This covers the level and the four flags after a handshake, the thresholds after `thr_we`, `ovf_flag` after a discarded write, `udf_pulse` after an empty read, and `rx_halt` after the edge at which the buffer is full. `rd_data`, `wr_ready` and `rd_valid` are combinational from stored state, so they follow that same edge. The bench changes inputs 1 ns after a rising edge and samples 1 ns after the next one, so every check sees exactly one edge of effect. The threshold sweep covers every level from 0 to 16 with every threshold from 0 to 17, and each flag is compared against a value computed arithmetically from that level and threshold.

// File: rtl/chan_fifo_pkg.sv
package chan_fifo_pkg;
  localparam int REG_W     = 16;
  localparam int THR_RESET = 7;

  typedef struct packed {
    logic full;
    logic afull;
    logic aempty;
    logic empty;
  } fifo_cond_t;
endpackage

// File: rtl/cbf_ctrl.sv
module cbf_ctrl #(
  parameter int DEPTH = 16,
  parameter int PTR_W = 4,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic             rd_ready,
  input  logic             flush_req,
  output logic             push,
  output logic             pop,
  output logic             drop,
  output logic             starve,
  output logic             flush_pulse,
  output logic             is_full,
  output logic             is_empty,
  output logic [PTR_W-1:0] wr_ptr,
  output logic [PTR_W-1:0] rd_ptr,
  output logic [LVL_W-1:0] level
);
  localparam logic [LVL_W-1:0] LVL_MAX  = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] LVL_ONE  = LVL_W'(1);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [PTR_W-1:0] PTR_ONE  = PTR_W'(1);

  logic flush_req_q;

  function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
    return (p == PTR_LAST) ? '0 : p + PTR_ONE;
  endfunction

  assign is_full     = (level == LVL_MAX);
  assign is_empty    = (level == '0);
  assign flush_pulse = flush_req & ~flush_req_q;
  assign push        = wr_valid & ~is_full  & ~flush_pulse;
  assign drop        = wr_valid &  is_full  & ~flush_pulse;
  assign pop         = rd_ready & ~is_empty & ~flush_pulse;
  assign starve      = rd_ready &  is_empty & ~flush_pulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flush_req_q <= 1'b0;
      wr_ptr      <= '0;
      rd_ptr      <= '0;
      level       <= '0;
    end else begin
      flush_req_q <= flush_req;
      if (flush_pulse) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
        level  <= '0;
      end else begin
        if (push) wr_ptr <= ptr_step(wr_ptr);
        if (pop)  rd_ptr <= ptr_step(rd_ptr);
        if (push && !pop)      level <= level + LVL_ONE;
        else if (pop && !push) level <= level - LVL_ONE;
      end
    end
  end
endmodule

// File: rtl/cbf_store.sv
module cbf_store #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int PTR_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              is_empty,
  input  logic [PTR_W-1:0]  wr_ptr,
  input  logic [PTR_W-1:0]  rd_ptr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   last_q <= '0;
    else if (pop) last_q <= mem[rd_ptr];
  end

  assign rd_data = is_empty ? last_q : mem[rd_ptr];
endmodule

// File: rtl/cbf_flags.sv
module cbf_flags
  import chan_fifo_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int LVL_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             thr_we,
  input  logic [REG_W-1:0] afull_in,
  input  logic [REG_W-1:0] aempty_in,
  input  logic [LVL_W-1:0] level,
  input  logic             is_full,
  input  logic             is_empty,
  output logic [REG_W-1:0] afull_q,
  output logic [REG_W-1:0] aempty_q,
  output fifo_cond_t       cond
);
  localparam int SUM_W = REG_W + 1;
  localparam logic [SUM_W-1:0] CAP = SUM_W'(DEPTH);

  logic [SUM_W-1:0] lvl_wide;
  logic [SUM_W-1:0] reach;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      afull_q  <= REG_W'(THR_RESET);
      aempty_q <= REG_W'(THR_RESET);
    end else if (thr_we) begin
      afull_q  <= afull_in;
      aempty_q <= aempty_in;
    end
  end

  assign lvl_wide    = SUM_W'(level);
  assign reach       = lvl_wide + {1'b0, afull_q};
  assign cond.full   = is_full;
  assign cond.empty  = is_empty;
  assign cond.afull  = (reach >= CAP);
  assign cond.aempty = (lvl_wide <= {1'b0, aempty_q});
endmodule

// File: rtl/cbf_errs.sv
module cbf_errs (
  input  logic clk,
  input  logic rst_n,
  input  logic drop,
  input  logic starve,
  input  logic ovf_clr,
  input  logic stop_on_full,
  input  logic is_full,
  input  logic flush_pulse,
  output logic ovf_q,
  output logic udf_q,
  output logic halt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
      halt_q <= 1'b0;
    end else begin
      if (drop)         ovf_q <= 1'b1;
      else if (ovf_clr) ovf_q <= 1'b0;
      udf_q <= starve;
      if (flush_pulse || !stop_on_full) halt_q <= 1'b0;
      else if (is_full)                 halt_q <= 1'b1;
    end
  end
endmodule

// File: rtl/chan_byte_fifo.sv
module chan_byte_fifo
  import chan_fifo_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [DATA_W-1:0] wr_data,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  input  logic              flush_req,
  input  logic              thr_we,
  input  logic [REG_W-1:0]  afull_thr_in,
  input  logic [REG_W-1:0]  aempty_thr_in,
  output logic [REG_W-1:0]  afull_thr,
  output logic [REG_W-1:0]  aempty_thr,
  output logic [REG_W-1:0]  fill_level,
  output logic [REG_W-1:0]  depth_words,
  output logic              full_n,
  output logic              afull_n,
  output logic              aempty_n,
  output logic              empty_n,
  input  logic              ovf_clr,
  output logic              ovf_flag,
  output logic              udf_pulse,
  input  logic              stop_on_full,
  output logic              rx_halt
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int LVL_W = $clog2(DEPTH + 1);
  localparam int NCOND = $bits(fifo_cond_t);

  logic             push, pop, drop, starve, flush_pulse;
  logic             is_full, is_empty;
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [LVL_W-1:0] level;
  fifo_cond_t       cond;
  logic [NCOND-1:0] cond_bits;
  logic [NCOND-1:0] cond_n;

  cbf_ctrl #(.DEPTH(DEPTH), .PTR_W(PTR_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .rd_ready(rd_ready),
    .flush_req(flush_req), .push(push), .pop(pop), .drop(drop),
    .starve(starve), .flush_pulse(flush_pulse), .is_full(is_full),
    .is_empty(is_empty), .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .level(level)
  );

  cbf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .PTR_W(PTR_W)) u_store (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .is_empty(is_empty),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .wr_data(wr_data), .rd_data(rd_data)
  );

  cbf_flags #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .thr_we(thr_we), .afull_in(afull_thr_in),
    .aempty_in(aempty_thr_in), .level(level), .is_full(is_full),
    .is_empty(is_empty), .afull_q(afull_thr), .aempty_q(aempty_thr),
    .cond(cond)
  );

  cbf_errs u_errs (
    .clk(clk), .rst_n(rst_n), .drop(drop), .starve(starve),
    .ovf_clr(ovf_clr), .stop_on_full(stop_on_full), .is_full(is_full),
    .flush_pulse(flush_pulse), .ovf_q(ovf_flag), .udf_q(udf_pulse),
    .halt_q(rx_halt)
  );

  assign cond_bits = cond;
  for (genvar i = 0; i < NCOND; i++) begin : g_low
    assign cond_n[i] = ~cond_bits[i];
  end

  assign {full_n, afull_n, aempty_n, empty_n} = cond_n;
  assign wr_ready    = ~is_full;
  assign rd_valid    = ~is_empty;
  assign fill_level  = REG_W'(level);
  assign depth_words = REG_W'(DEPTH);
endmodule

// File: rtl/chan_byte_fifo_chk.sv
module chan_byte_fifo_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_valid,
  input logic        wr_ready,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        flush_req,
  input logic        thr_we,
  input logic [15:0] afull_thr_in,
  input logic [15:0] afull_thr,
  input logic [15:0] fill_level,
  input logic        full_n,
  input logic        afull_n,
  input logic        empty_n,
  input logic        ovf_clr,
  input logic        ovf_flag,
  input logic        udf_pulse,
  input logic        stop_on_full,
  input logic        rx_halt
);
  p_level_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fill_level) <= DEPTH);

  p_full_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_level) == DEPTH) |-> !full_n);

  p_empty_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_level == 16'd0) |-> !empty_n);

  p_afull_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fill_level) + int'(afull_thr) >= DEPTH) |-> !afull_n);

  p_thr_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    thr_we |=> (afull_thr == $past(afull_thr_in)));

  p_ovf_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !flush_req) |=> ovf_flag);

  p_ovf_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag);

  p_udf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ready && !rd_valid && !flush_req) |=> udf_pulse);

  p_level_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && rd_valid && rd_ready && !flush_req)
      |=> $stable(fill_level));

  p_halt_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_on_full && !full_n && !flush_req) |=> rx_halt);
endmodule

bind chan_byte_fifo chan_byte_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .flush_req(flush_req),
  .thr_we(thr_we), .afull_thr_in(afull_thr_in), .afull_thr(afull_thr),
  .fill_level(fill_level), .full_n(full_n), .afull_n(afull_n),
  .empty_n(empty_n), .ovf_clr(ovf_clr), .ovf_flag(ovf_flag),
  .udf_pulse(udf_pulse), .stop_on_full(stop_on_full), .rx_halt(rx_halt)
);

// File: tb/chan_byte_fifo_bench.sv
`timescale 1ns/100ps
module chan_byte_fifo_bench;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0, rd_ready = 1'b0, flush_req = 1'b0;
  logic        thr_we = 1'b0, ovf_clr = 1'b0, stop_on_full = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [15:0] afull_thr_in = 16'd0, aempty_thr_in = 16'd0;
  logic        wr_ready, rd_valid, full_n, afull_n, aempty_n, empty_n;
  logic        ovf_flag, udf_pulse, rx_halt;
  logic [7:0]  rd_data;
  logic [15:0] afull_thr, aempty_thr, fill_level, depth_words;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] model [$];
  logic [7:0] last_out = 8'h00;

  always #2.5 clk = ~clk;

  chan_byte_fifo u_chan_byte_fifo (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_data(rd_data), .flush_req(flush_req), .thr_we(thr_we),
    .afull_thr_in(afull_thr_in), .aempty_thr_in(aempty_thr_in),
    .afull_thr(afull_thr), .aempty_thr(aempty_thr), .fill_level(fill_level),
    .depth_words(depth_words), .full_n(full_n), .afull_n(afull_n),
    .aempty_n(aempty_n), .empty_n(empty_n), .ovf_clr(ovf_clr),
    .ovf_flag(ovf_flag), .udf_pulse(udf_pulse), .stop_on_full(stop_on_full),
    .rx_halt(rx_halt)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push_byte(input logic [7:0] d);
    wr_valid = 1'b1;
    wr_data  = d;
    if (model.size() < DEPTH) model.push_back(d);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic pop_byte(input string req);
    check(req, rd_data, model[0]);
    last_out = model.pop_front();
    rd_ready = 1'b1;
    tick();
    rd_ready = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    // Reset state
    check("R2 level", fill_level, 0);
    check("R2 depth", depth_words, DEPTH);
    check("R3 empty_n", empty_n, 0);
    check("R3 full_n", full_n, 1);
    check("R1 wr_ready", wr_ready, 1);
    check("R1 rd_valid", rd_valid, 0);
    check("R6 afull reset", afull_thr, 7);
    check("R6 aempty reset", aempty_thr, 7);
    check("R7 ovf reset", ovf_flag, 0);
    check("R8 udf reset", udf_pulse, 0);
    check("R11 halt reset", rx_halt, 0);
    check("R4 afull at 0 thr 7", afull_n, 1);
    check("R5 aempty at 0 thr 7", aempty_n, 0);

    // Sweep every level against every threshold
    for (int lvl = 0; lvl <= DEPTH; lvl++) begin
      check("R2 level sweep", fill_level, lvl);
      check("R3 full sweep", full_n, (lvl == DEPTH) ? 0 : 1);
      check("R3 empty sweep", empty_n, (lvl == 0) ? 0 : 1);
      for (int t = 0; t <= DEPTH + 1; t++) begin
        thr_we = 1'b1;
        afull_thr_in  = 16'(t);
        aempty_thr_in = 16'(DEPTH + 1 - t);
        tick();
        thr_we = 1'b0;
        check("R6 afull load", afull_thr, t);
        check("R4 afull sweep", afull_n, (lvl + t >= DEPTH) ? 0 : 1);
        check("R5 aempty sweep", aempty_n,
              (lvl <= DEPTH + 1 - t) ? 0 : 1);
      end
      if (lvl < DEPTH) push_byte(8'((lvl * 37 + 5) & 8'hFF));
    end

    // Full: discarded write and sticky overflow
    check("R1 wr_ready full", wr_ready, 0);
    push_byte(8'hEE);
    check("R7 ovf set", ovf_flag, 1);
    check("R7 level unchanged", fill_level, DEPTH);
    tick();
    check("R7 ovf sticky", ovf_flag, 1);
    ovf_clr = 1'b1;
    tick();
    ovf_clr = 1'b0;
    check("R7 ovf cleared", ovf_flag, 0);
    wr_valid = 1'b1;
    ovf_clr = 1'b1;
    tick();
    wr_valid = 1'b0;
    ovf_clr = 1'b0;
    check("R7 set beats clear", ovf_flag, 1);
    ovf_clr = 1'b1;
    tick();
    ovf_clr = 1'b0;

    // Stop-on-full halt
    stop_on_full = 1'b1;
    tick();
    check("R11 halt rises", rx_halt, 1);
    pop_byte("R1 first out");
    check("R11 halt sticky", rx_halt, 1);
    check("R2 level after pop", fill_level, DEPTH - 1);
    stop_on_full = 1'b0;
    tick();
    check("R11 halt dropped", rx_halt, 0);

    // Simultaneous push and pop
    check("R1 head before both", rd_data, model[0]);
    last_out = model.pop_front();
    model.push_back(8'hA5);
    wr_valid = 1'b1;
    wr_data  = 8'hA5;
    rd_ready = 1'b1;
    tick();
    wr_valid = 1'b0;
    rd_ready = 1'b0;
    check("R9 level held", fill_level, DEPTH - 1);

    // Drain in order
    while (model.size() > 0) pop_byte("R1 order");
    check("R3 empty after drain", empty_n, 0);

    // Read while empty
    rd_ready = 1'b1;
    tick();
    rd_ready = 1'b0;
    check("R8 udf pulse", udf_pulse, 1);
    check("R8 level held", fill_level, 0);
    check("R8 last data", rd_data, last_out);
    check("R8 last is A5", rd_data, 8'hA5);
    tick();
    check("R8 udf one cycle", udf_pulse, 0);

    // Flush behaviour
    for (int i = 0; i < 5; i++) push_byte(8'(i + 8'h40));
    check("R10 pre-flush level", fill_level, 5);
    flush_req = 1'b1;
    wr_valid  = 1'b1;
    wr_data   = 8'h99;
    tick();
    wr_valid = 1'b0;
    model.delete();
    check("R10 flushed", fill_level, 0);
    check("R10 no ovf", ovf_flag, 0);
    push_byte(8'h11);
    push_byte(8'h22);
    check("R10 held no reflush", fill_level, 2);
    check("R10 head data", rd_data, 8'h11);
    flush_req = 1'b0;
    tick();

    // Halt cleared by flush
    stop_on_full = 1'b1;
    while (model.size() < DEPTH) push_byte(8'(model.size()));
    tick();
    check("R11 halt on refill", rx_halt, 1);
    flush_req = 1'b1;
    tick();
    flush_req = 1'b0;
    model.delete();
    check("R11 halt cleared by flush", rx_halt, 0);
    check("R10 flush from full", fill_level, 0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule